// File: doc/BRIEF.md
# Double-Buffered Serial Control Register

This block is the programming port of a frequency synthesizer. A host shifts configuration bits in over three wires: data, clock and a load strobe. Each bit is taken on a rising edge of the serial clock, most significant bit first. A separate write enable steers the bits either into a 20-bit main word or into an 8-bit auxiliary word.

A rising edge on the load strobe copies the main word into a shadow copy. A static select pin picks the live copy. With select high, the divider configuration follows the main word directly. With select low, it follows the shadow copy, so a new word can be prepared while the old one stays in effect.

An active-low mode pin enables the auxiliary word and a data-out pin. All serial pins are asynchronous to the system clock. They pass through synchronisers, and their edges are detected in the system clock domain.

Top module: `serial_ctrl_reg`

## Requirements
- R1: Each detected rising edge of `serClk` shifts the synchronised `serData` into bit 0 of the 20-bit main word and moves the earlier bits up one place, so the first bit sent ends in bit 19.
- R2: While `loadStrobe` is high, serial clock edges leave the main word unchanged.
- R3: While `enhWrEn` is high, serial clock edges leave the main word unchanged.
- R4: While `enhWrEn` is high, each serial clock edge shifts `serData` into bit 0 of the 8-bit auxiliary word, so the first bit sent ends in bit 7.
- R5: A rising edge of `loadStrobe` copies the main word into the shadow word.
- R6: The shadow word changes only on a rising edge of `loadStrobe`. Shifting a new main word leaves it untouched.
- R7: `counterWord` shows the main word when `freqSel` is 1 and the shadow word when `freqSel` is 0.
- R8: While `enhModeN` is 1, `enhWord` reads all zeros and `dataOut` is 0. The auxiliary word is kept, and it shows again once `enhModeN` returns to 0.
- R9: While `enhModeN` is 0, `dataOut` equals bit 19 of the main word.
- R10: Reset clears the main, shadow and auxiliary words to zero.
- R11: When more than 20 bits are shifted, the main word holds the last 20 bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| serClk | input | 1 | Serial clock, asynchronous |
| serData | input | 1 | Serial data, MSB first |
| loadStrobe | input | 1 | Low while shifting; its rising edge copies main to shadow |
| enhWrEn | input | 1 | High steers serial bits into the auxiliary word |
| enhModeN | input | 1 | Active-low enable of the auxiliary word and data-out |
| freqSel | input | 1 | 1 selects the main word, 0 the shadow word |
| counterWord | output | 20 | Live divider configuration word |
| enhWord | output | 8 | Auxiliary word, zero when the mode is off |
| dataOut | output | 1 | MSB of the main word when the mode is on, else 0 |

## Verification
The bench runs several scenarios that a faulty design would get visibly wrong:
- **Shift path that ignores the gating inputs.** The bench clocks an all-ones word with the strobe held high. A design that does not gate on the strobe would corrupt the main word.
- **Auxiliary write that also touches the main word.** The bench writes the auxiliary word and checks that the main word is unchanged. A design that shifts both would show a changed main word.
- **Shadow copy that follows the main word.** The bench shifts a new main word with the shadow selected. A shadow that tracks the main word, instead of waiting for the strobe edge, would expose the new bits at once.
- **Over-length shift.** A 24-bit shift must keep only the last 20 bits. A register that saturates, or keeps the oldest bits, would fail this check.
- **Mode off and back on.** Disabling the mode must zero the outputs without erasing the stored auxiliary word.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int MAIN_W = 20;
  localparam int ENH_W  = 8;

  typedef struct packed {
    logic shiftMain;
    logic shiftEnh;
    logic loadSec;
    logic bitVal;
  } sctl_strobes_t;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= RST_VAL;
        else if (s == 0) stage[s] <= din;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/sctl_ctrl.sv
module sctl_ctrl
  import sctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          serClk,
  input  logic          serData,
  input  logic          loadStrobe,
  input  logic          enhWrEn,
  input  logic          enhModeN,
  input  logic          freqSel,
  output sctl_strobes_t strobes,
  output logic          modeActive,
  output logic          selPrimary
);
  localparam int NPINS = 6;
  localparam logic [NPINS-1:0] PIN_RST = 6'b000010;

  logic [NPINS-1:0] rawPins;
  logic [NPINS-1:0] syncPins;
  logic clkS, dataS, loadS, enhWrS, modeNS, selS;
  logic clkPrev, loadPrev;

  assign rawPins = {serClk, serData, loadStrobe, enhWrEn, enhModeN, freqSel};
  assign {clkS, dataS, loadS, enhWrS, modeNS, selS} = syncPins;

  sctl_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) pinSync_i (
    .clk(clk), .rst_n(rst_n), .din(rawPins), .dout(syncPins)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      clkPrev  <= clkS;
      loadPrev <= loadS;
    end
  end

  logic clkRise;
  assign clkRise = clkS & ~clkPrev;

  always_comb begin
    strobes.shiftMain = clkRise & ~loadS & ~enhWrS;
    strobes.shiftEnh  = clkRise & enhWrS;
    strobes.loadSec   = loadS & ~loadPrev;
    strobes.bitVal    = dataS;
  end

  assign modeActive = ~modeNS;
  assign selPrimary = selS;
endmodule

// File: rtl/sctl_datapath.sv
module sctl_datapath
  import sctl_pkg::*;
#(
  parameter int MW = MAIN_W,
  parameter int EW = ENH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sctl_strobes_t strobes,
  input  logic          modeActive,
  input  logic          selPrimary,
  output logic [MW-1:0] primReg,
  output logic [MW-1:0] secReg,
  output logic [EW-1:0] enhReg,
  output logic [MW-1:0] counterWord,
  output logic [EW-1:0] enhWord,
  output logic          dataOut
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primReg <= '0;
      secReg  <= '0;
      enhReg  <= '0;
    end else begin
      if (strobes.shiftMain) primReg <= {primReg[MW-2:0], strobes.bitVal};
      if (strobes.shiftEnh)  enhReg  <= {enhReg[EW-2:0], strobes.bitVal};
      if (strobes.loadSec)   secReg  <= primReg;
    end
  end

  assign counterWord = selPrimary ? primReg : secReg;
  assign enhWord     = modeActive ? enhReg : '0;
  assign dataOut     = modeActive & primReg[MW-1];
endmodule

// File: rtl/serial_ctrl_reg.sv
module serial_ctrl_reg
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serClk,
  input  logic              serData,
  input  logic              loadStrobe,
  input  logic              enhWrEn,
  input  logic              enhModeN,
  input  logic              freqSel,
  output logic [MAIN_W-1:0] counterWord,
  output logic [ENH_W-1:0]  enhWord,
  output logic              dataOut
);
  sctl_strobes_t     strobes;
  logic              modeActive;
  logic              selPrimary;
  logic [MAIN_W-1:0] primReg;
  logic [MAIN_W-1:0] secReg;
  logic [ENH_W-1:0]  enhReg;

  sctl_ctrl #(.SYNC_STAGES(2)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .loadStrobe(loadStrobe), .enhWrEn(enhWrEn), .enhModeN(enhModeN),
    .freqSel(freqSel), .strobes(strobes), .modeActive(modeActive),
    .selPrimary(selPrimary)
  );

  sctl_datapath #(.MW(MAIN_W), .EW(ENH_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .modeActive(modeActive),
    .selPrimary(selPrimary), .primReg(primReg), .secReg(secReg),
    .enhReg(enhReg), .counterWord(counterWord), .enhWord(enhWord),
    .dataOut(dataOut)
  );
endmodule

// File: rtl/sctl_checker.sv
module sctl_checker
  import sctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input sctl_strobes_t     strobes,
  input logic              enhModeN,
  input logic [MAIN_W-1:0] primReg,
  input logic [MAIN_W-1:0] secReg,
  input logic [ENH_W-1:0]  enhReg,
  input logic [ENH_W-1:0]  enhWord,
  input logic              dataOut
);
  assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.shiftMain, strobes.shiftEnh}));

  assert_main_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.shiftMain |=> $stable(primReg));

  assert_aux_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.shiftEnh |=> $stable(enhReg));

  assert_copy_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadSec |=> secReg == $past(primReg));

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.loadSec |=> $stable(secReg));

  assert_mode_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enhModeN && $past(enhModeN) && $past(enhModeN, 2)) |-> (enhWord == '0 && !dataOut));
endmodule

bind serial_ctrl_reg sctl_checker chk_i (
  .clk(clk), .rst_n(rst_n), .strobes(strobes), .enhModeN(enhModeN),
  .primReg(primReg), .secReg(secReg), .enhReg(enhReg),
  .enhWord(enhWord), .dataOut(dataOut)
);

// File: tb/serial_ctrl_reg_tb_top.sv
module serial_ctrl_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SER_HALF   = 8 * CLK_PERIOD;

  typedef struct packed {
    logic [19:0] cw;
    logic [7:0]  ew;
    logic        dout;
  } expItem_t;

  logic clk = 0;
  logic rst_n = 0;
  logic serClk = 0, serData = 0, loadStrobe = 0, enhWrEn = 0;
  logic enhModeN = 1, freqSel = 1;
  logic [19:0] counterWord;
  logic [7:0]  enhWord;
  logic        dataOut;

  int total = 0;
  int bad = 0;
  bit done = 0;
  expItem_t expQ[$];
  string    tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .loadStrobe(loadStrobe), .enhWrEn(enhWrEn), .enhModeN(enhModeN),
    .freqSel(freqSel), .counterWord(counterWord), .enhWord(enhWord),
    .dataOut(dataOut)
  );

  task automatic shiftBits(input logic [31:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = val[i];
      #(SER_HALF);
      serClk = 1;
      #(SER_HALF);
      serClk = 0;
    end
    #(SER_HALF);
  endtask

  task automatic pulseLoad();
    loadStrobe = 1;
    repeat (8) @(posedge clk);
    loadStrobe = 0;
    repeat (8) @(posedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [19:0] cw,
                            input logic [7:0] ew, input logic dout);
    expItem_t it;
    it.cw = cw; it.ew = ew; it.dout = dout;
    expQ.push_back(it);
    tagQ.push_back(tag);
    repeat (20) @(posedge clk);
  endtask

  // monitor: pop expected item, let synchronisers settle, compare
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t it;
        string tag;
        it  = expQ.pop_front();
        tag = tagQ.pop_front();
        repeat (8) @(negedge clk);
        total++;
        if (counterWord !== it.cw || enhWord !== it.ew || dataOut !== it.dout) begin
          bad++;
          $display("FAIL %s: actual cw=%h ew=%h dout=%b expected cw=%h ew=%h dout=%b",
                   tag, counterWord, enhWord, dataOut, it.cw, it.ew, it.dout);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1;
    expect_out("R10 reset", 20'h0, 8'h00, 1'b0);

    shiftBits(32'hA5C3E, 20);
    expect_out("R1 msb-first main", 20'hA5C3E, 8'h00, 1'b0);

    enhModeN = 0;
    expect_out("R9 dout=msb", 20'hA5C3E, 8'h00, 1'b1);

    enhWrEn = 1;
    repeat (5) @(posedge clk);
    shiftBits(32'h96, 8);
    enhWrEn = 0;
    expect_out("R3/R4 aux write", 20'hA5C3E, 8'h96, 1'b1);

    enhModeN = 1;
    expect_out("R8 mode off", 20'hA5C3E, 8'h00, 1'b0);
    enhModeN = 0;
    expect_out("R8 aux retained", 20'hA5C3E, 8'h96, 1'b1);

    pulseLoad();
    freqSel = 0;
    expect_out("R5 shadow copy", 20'hA5C3E, 8'h96, 1'b1);

    shiftBits(32'h1234F, 20);
    expect_out("R6 shadow holds", 20'hA5C3E, 8'h96, 1'b0);

    freqSel = 1;
    expect_out("R7 select main", 20'h1234F, 8'h96, 1'b0);

    loadStrobe = 1;
    repeat (8) @(posedge clk);
    shiftBits(32'hFFFFF, 20);
    expect_out("R2 strobe blocks shift", 20'h1234F, 8'h96, 1'b0);
    loadStrobe = 0;
    repeat (8) @(posedge clk);

    shiftBits(32'hABCDEF, 24);
    expect_out("R11 last 20 bits", 20'hBCDEF, 8'h96, 1'b1);

    freqSel = 0;
    expect_out("R7 select shadow", 20'h1234F, 8'h96, 1'b1);

    freqSel = 1;
    enhWrEn = 1;
    repeat (5) @(posedge clk);
    shiftBits(32'h3C, 8);
    enhWrEn = 0;
    expect_out("R3 main untouched", 20'hBCDEF, 8'h3C, 1'b1);

    pulseLoad();
    freqSel = 0;
    expect_out("R5 second copy", 20'hBCDEF, 8'h3C, 1'b1);

    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    expect_out("R10 mid-run reset", 20'h0, 8'h00, 1'b0);

    repeat (20) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule